// File: doc/BRIEF.md
# Timing Wheel Event Scheduler

This block keeps a set of timestamped events and hands them back one at a time in time order. It replaces a sorted priority queue with a circular array of sixteen one-unit time slots. Each slot holds a short first-in first-out list of event identifiers. Any event scheduled sixteen or more time units past the current time is parked in a small unsorted far store instead of a slot.

A client inserts an event by presenting an identifier and an absolute time for one cycle while the block is idle. To take the next event it raises a pop request. The block then scans forward from the slot of its current time, one slot per clock, until it finds a slot holding an event. It delivers the oldest event of that slot together with the slot's time, and the current time stops at that slot.

When the scan steps past the last slot, the window moves forward by sixteen time units and the scan returns to slot zero. The block then spends one clock per far-store entry moving every parked event that now falls inside the window into its slot. The current time is always at or before every stored event, so an entry in a slot always belongs to the slot's time when the scan reaches it.

Top module: `twheel_sched`

## Requirements
- R1: While reset is asserted and just after it is released, empty is 1, popValid, busy and overflow are 0, and nowTime is 0.
- R2: A pop delivers a stored event with the smallest time. popTime equals the time the event was inserted with, popId equals its identifier, and nowTime then equals popTime.
- R3: Events inserted directly into the wheel with equal times are delivered in the order they were inserted.
- R4: An event with time at least nowTime+16 is held in the far store and is still delivered in time order after the window has moved forward to include it.
- R5: empty is 1 exactly when neither the wheel nor the far store holds an event, and it does not fall without an accepted insert.
- R6: popValid is a single-cycle pulse raised only when an event is delivered. A pop request while empty is 1 produces no popValid and leaves busy at 0.
- R7: An insert into a slot already holding 4 events, or a far-routed insert while all 8 far entries are in use, is dropped and sets overflow. overflow stays 1 until reset.
- R8: An insert presented while busy is 1 is ignored and leaves the stored contents unchanged.
- R9: If the request is accepted at clock edge E, popValid is first seen after edge E+d+1+8w. Here d is popTime minus nowTime at the request and w is the number of window moves crossed, which is popTime/16 minus that nowTime/16. nowTime does not change while busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| insValid | input | 1 | Insert strobe, honoured only while idle |
| insId | input | 8 | Identifier of the event being inserted |
| insTime | input | 16 | Absolute time of the event being inserted, not below nowTime |
| popReq | input | 1 | Request delivery of the earliest event |
| popValid | output | 1 | One-cycle pulse marking a delivered event |
| popId | output | 8 | Identifier of the delivered event |
| popTime | output | 16 | Time of the delivered event |
| nowTime | output | 16 | Current scan time |
| busy | output | 1 | A pop scan or far-store transfer is in progress |
| empty | output | 1 | No event is stored |
| overflow | output | 1 | Sticky flag for a dropped insert |

## Verification
The bench sends batches of events spread over about four windows, so many of them pass through the far store and back. A design that mapped far events to the wrong slot, or skipped the transfer after a window move, would deliver them out of order or at the wrong time. Equal-time events check the slot list order; a last-in first-out slot would swap their identifiers. Every pop is timed against the one-slot-per-clock rule with its transfer cycles, so a scan that skipped slots or stopped early would miss the expected cycle. The bench also fills a slot and the far store one event past their limits, sends an insert during a long scan, and pops while empty; a wrong bound, a flag that clears itself, or an insert taken while busy would show at overflow, empty or the next pop.

// File: rtl/twheel_pkg.sv
package twheel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_REFILL
  } wheelState_t;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic insert;   // accept the presented event
    logic pop;      // deliver head of the current slot
    logic advance;  // step current time by one quantum
    logic refill;   // examine one far-store entry
  } wheelStrobe_t;

endpackage

// File: rtl/twheel_ctrl.sv
module twheel_ctrl
  import twheel_pkg::*;
#(
  parameter int FAR_DEPTH = 8,
  localparam int FAR_W = $clog2(FAR_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  input  logic               popReq,
  input  logic               slotHit,
  input  logic               storeEmpty,
  input  logic               lastSlot,
  output wheelStrobe_t       strobe,
  output logic [FAR_W-1:0]   refillIdx,
  output logic               busy
);

  wheelState_t state, nextState;
  logic [FAR_W-1:0] refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      refCnt <= '0;
    end else begin
      state  <= nextState;
      refCnt <= (state == ST_REFILL) ? refCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        strobe.insert = insValid;
        if (popReq && !storeEmpty) nextState = ST_SCAN;
      end
      ST_SCAN: begin
        if (slotHit) begin
          strobe.pop = 1'b1;
          nextState  = ST_IDLE;
        end else if (storeEmpty) begin
          nextState = ST_IDLE;
        end else begin
          strobe.advance = 1'b1;
          if (lastSlot) nextState = ST_REFILL;
        end
      end
      ST_REFILL: begin
        strobe.refill = 1'b1;
        if (refCnt == FAR_W'(FAR_DEPTH - 1)) nextState = ST_SCAN;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign refillIdx = refCnt;
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/twheel_dp.sv
module twheel_dp
  import twheel_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,   // power of two, one time unit each
  parameter int SLOT_DEPTH = 4,    // power of two
  parameter int FAR_DEPTH  = 8,
  parameter int TIME_W     = 16,
  parameter int ID_W       = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int DEP_W = $clog2(SLOT_DEPTH),
  localparam int CNT_W = $clog2(SLOT_DEPTH + 1),
  localparam int FAR_W = $clog2(FAR_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wheelStrobe_t      strobe,
  input  logic [FAR_W-1:0]  refillIdx,
  input  logic [ID_W-1:0]   insId,
  input  logic [TIME_W-1:0] insTime,
  output logic              slotHit,
  output logic              storeEmpty,
  output logic              lastSlot,
  output logic [TIME_W-1:0] nowTime,
  output logic              popValid,
  output logic [ID_W-1:0]   popId,
  output logic [TIME_W-1:0] popTime,
  output logic              overflow
);

  localparam logic [TIME_W-1:0] SPAN = TIME_W'(NUM_SLOTS);

  logic [TIME_W-1:0] curTime;
  logic [IDX_W-1:0]  curIdx;
  assign curIdx = curTime[IDX_W-1:0];

  // far store
  logic [FAR_DEPTH-1:0] farValid;
  logic [TIME_W-1:0]    farTime [FAR_DEPTH];
  logic [ID_W-1:0]      farId   [FAR_DEPTH];

  // per-slot views
  logic [CNT_W-1:0] slotCnt  [NUM_SLOTS];
  logic [ID_W-1:0]  slotHead [NUM_SLOTS];

  // routing of the single slot write port
  logic [TIME_W-1:0] insDist, rfTime, rfDist;
  logic              insNear, rfMove, farWr, haveFree, slotFull, slotPush;
  logic              wrEn;
  logic [IDX_W-1:0]  wrSlot;
  logic [ID_W-1:0]   wrId;
  logic [FAR_W-1:0]  freeIdx;

  assign insDist  = insTime - curTime;
  assign insNear  = insDist < SPAN;
  assign rfTime   = farTime[refillIdx];
  assign rfDist   = rfTime - curTime;
  assign rfMove   = strobe.refill && farValid[refillIdx] && (rfDist < SPAN);
  assign farWr    = strobe.insert && !insNear;
  assign haveFree = !(&farValid);

  always_comb begin
    wrEn   = 1'b0;
    wrSlot = '0;
    wrId   = '0;
    if (strobe.insert && insNear) begin
      wrEn   = 1'b1;
      wrSlot = insTime[IDX_W-1:0];
      wrId   = insId;
    end else if (rfMove) begin
      wrEn   = 1'b1;
      wrSlot = rfTime[IDX_W-1:0];
      wrId   = farId[refillIdx];
    end
  end

  assign slotFull = (slotCnt[wrSlot] == CNT_W'(SLOT_DEPTH));
  assign slotPush = wrEn && !slotFull;

  always_comb begin
    freeIdx = '0;
    for (int i = FAR_DEPTH - 1; i >= 0; i--) begin
      if (!farValid[i]) freeIdx = FAR_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      farValid <= '0;
    end else begin
      if (farWr && haveFree) begin
        farValid[freeIdx] <= 1'b1;
        farTime[freeIdx]  <= insTime;
        farId[freeIdx]    <= insId;
      end
      if (rfMove) farValid[refillIdx] <= 1'b0;
    end
  end

  // slot lists
  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
      logic [ID_W-1:0]  mem [SLOT_DEPTH];
      logic [DEP_W-1:0] rdP, wrP;
      logic [CNT_W-1:0] cnt;
      logic             doPush, doPop;

      assign doPush = slotPush && (wrSlot == IDX_W'(g));
      assign doPop  = strobe.pop && (curIdx == IDX_W'(g));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rdP <= '0;
          wrP <= '0;
          cnt <= '0;
        end else begin
          if (doPush) begin
            mem[wrP] <= wrId;
            wrP      <= wrP + 1'b1;
          end
          if (doPop) rdP <= rdP + 1'b1;
          case ({doPush, doPop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
          endcase
        end
      end

      assign slotCnt[g]  = cnt;
      assign slotHead[g] = mem[rdP];
    end
  endgenerate

  logic wheelAny;
  always_comb begin
    wheelAny = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) wheelAny = wheelAny | (slotCnt[i] != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curTime  <= '0;
      overflow <= 1'b0;
      popValid <= 1'b0;
      popId    <= '0;
      popTime  <= '0;
    end else begin
      if (strobe.advance) curTime <= curTime + 1'b1;
      if ((wrEn && slotFull) || (farWr && !haveFree)) overflow <= 1'b1;
      popValid <= strobe.pop;
      if (strobe.pop) begin
        popId   <= slotHead[curIdx];
        popTime <= curTime;
      end
    end
  end

  assign slotHit    = (slotCnt[curIdx] != '0);
  assign storeEmpty = !wheelAny && (farValid == '0);
  assign lastSlot   = (curIdx == IDX_W'(NUM_SLOTS - 1));
  assign nowTime    = curTime;

endmodule

// File: rtl/twheel_sched.sv
module twheel_sched
  import twheel_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int SLOT_DEPTH = 4,
  parameter int FAR_DEPTH  = 8,
  parameter int TIME_W     = 16,
  parameter int ID_W       = 8,
  localparam int FAR_W = $clog2(FAR_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [ID_W-1:0]   insId,
  input  logic [TIME_W-1:0] insTime,
  input  logic              popReq,
  output logic              popValid,
  output logic [ID_W-1:0]   popId,
  output logic [TIME_W-1:0] popTime,
  output logic [TIME_W-1:0] nowTime,
  output logic              busy,
  output logic              empty,
  output logic              overflow
);

  wheelStrobe_t     strobe;
  logic [FAR_W-1:0] refillIdx;
  logic             slotHit, storeEmpty, lastSlot;

  twheel_ctrl #(.FAR_DEPTH(FAR_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .popReq(popReq),
    .slotHit(slotHit), .storeEmpty(storeEmpty), .lastSlot(lastSlot),
    .strobe(strobe), .refillIdx(refillIdx), .busy(busy)
  );

  twheel_dp #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_DEPTH(SLOT_DEPTH), .FAR_DEPTH(FAR_DEPTH),
    .TIME_W(TIME_W), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refillIdx(refillIdx),
    .insId(insId), .insTime(insTime), .slotHit(slotHit),
    .storeEmpty(storeEmpty), .lastSlot(lastSlot), .nowTime(nowTime),
    .popValid(popValid), .popId(popId), .popTime(popTime),
    .overflow(overflow)
  );

  assign empty = storeEmpty;

endmodule

// File: rtl/twheel_checker.sv
module twheel_checker #(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              insValid,
  input logic              popValid,
  input logic [TIME_W-1:0] popTime,
  input logic [TIME_W-1:0] nowTime,
  input logic              busy,
  input logic              empty,
  input logic              overflow
);

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    popValid |=> !popValid);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_stays_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !busy && !insValid) |=> empty);

  assert_idle_time_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(nowTime));

  assert_pop_time_R2: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> (popTime == nowTime));

  assert_pop_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> !busy);

endmodule

bind twheel_sched twheel_checker #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rstN(rstN), .insValid(insValid), .popValid(popValid),
  .popTime(popTime), .nowTime(nowTime), .busy(busy), .empty(empty),
  .overflow(overflow)
);

// File: tb/twheel_sched_bench.sv
module twheel_sched_bench;
  localparam int NS = 16;
  localparam int FD = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insValid = 1'b0;
  logic [7:0]  insId = '0;
  logic [15:0] insTime = '0;
  logic        popReq = 1'b0;
  logic        popValid, busy, empty, overflow;
  logic [7:0]  popId;
  logic [15:0] popTime, nowTime;

  always #5 clk = ~clk;

  twheel_sched u_twheel_sched (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insId(insId),
    .insTime(insTime), .popReq(popReq), .popValid(popValid), .popId(popId),
    .popTime(popTime), .nowTime(nowTime), .busy(busy), .empty(empty),
    .overflow(overflow)
  );

  typedef struct { int id; int t; int seq; } ev_t;
  ev_t model[$];
  int  seqCtr = 0;
  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  monOn = 1'b0;
  int  lcg = 12345;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5: empty compared with the reference on every clock
  always @(posedge clk) begin
    #3;
    if (monOn) check("R5 empty flag", int'(empty), int'(model.size() == 0));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int nextRand();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >>> 8;
  endfunction

  task automatic doInsert(int id, int t, bit accept);
    @(negedge clk);
    insValid = 1'b1;
    insId    = 8'(id);
    insTime  = 16'(t);
    @(posedge clk);
    #1;
    insValid = 1'b0;
    if (accept) begin
      model.push_back('{id, t, seqCtr});
      seqCtr++;
    end
  endtask

  // pop and compare with the earliest model event; optional insert while busy
  task automatic doPop(string req, bit sneak);
    int now0, k, n, expLat;
    now0 = int'(nowTime);
    k = 0;
    for (int i = 1; i < model.size(); i++) begin
      if (model[i].t < model[k].t ||
          (model[i].t == model[k].t && model[i].seq < model[k].seq)) k = i;
    end
    @(negedge clk);
    popReq = 1'b1;
    @(posedge clk);
    #1;
    popReq = 1'b0;
    n = 0;
    while (n < 3000) begin
      @(posedge clk);
      #1;
      n++;
      if (sneak && n == 3) begin
        check("R8 busy during scan", int'(busy), 1);
        insValid = 1'b1;
        insId    = 8'd99;
        insTime  = 16'(now0 + 2);
      end
      if (sneak && n == 4) insValid = 1'b0;
      if (popValid) break;
    end
    check({req, " popValid"}, int'(popValid), 1);
    check({req, " popId"}, int'(popId), model[k].id);
    check({req, " popTime"}, int'(popTime), model[k].t);
    check("R2 nowTime after pop", int'(nowTime), model[k].t);
    expLat = (model[k].t - now0) + 1 + FD * (model[k].t / NS - now0 / NS);
    check("R9 scan latency", n, expLat);
    model.delete(k);
    @(posedge clk);
    #1;
    check("R6 popValid pulse", int'(popValid), 0);
  endtask

  task automatic doReset();
    monOn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset empty", int'(empty), 1);
    check("R1 reset popValid", int'(popValid), 0);
    check("R1 reset overflow", int'(overflow), 0);
    check("R1 reset nowTime", int'(nowTime), 0);
    check("R1 reset busy", int'(busy), 0);
    model.delete();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release empty", int'(empty), 1);
    monOn = 1'b1;
  endtask

  initial begin
    doReset();

    // R6: pop while empty
    @(negedge clk);
    popReq = 1'b1;
    @(posedge clk);
    #1;
    popReq = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check("R6 no pop when empty", int'(popValid), 0);
      check("R6 busy stays low", int'(busy), 0);
      @(posedge clk);
      #1;
    end

    // R3: equal-time events keep insertion order
    doInsert(1, 2, 1'b1);
    doInsert(2, 2, 1'b1);
    doInsert(3, 2, 1'b1);
    doInsert(4, 7, 1'b1);
    for (int i = 0; i < 4; i++) doPop("R3 tie order", 1'b0);

    // R4: lone far event, crossing window moves
    doInsert(10, int'(nowTime) + 40, 1'b1);
    doInsert(11, int'(nowTime) + 16, 1'b1);
    doPop("R4 far event", 1'b0);
    doPop("R4 far event", 1'b0);

    // R8: insert during a long scan is ignored
    doInsert(20, int'(nowTime) + 35, 1'b1);
    doPop("R8 scan with insert", 1'b1);
    repeat (2) @(posedge clk);
    #1;
    check("R8 store still empty", int'(empty), 1);

    // R2/R4: batches with distinct times spread over several windows
    for (int b = 0; b < 8; b++) begin
      int cnt;
      cnt = 3 + nextRand() % 6;
      for (int e = 0; e < cnt; e++) begin
        int t;
        bit clash;
        do begin
          t = int'(nowTime) + nextRand() % 60;
          clash = 1'b0;
          foreach (model[j]) if (model[j].t == t) clash = 1'b1;
        end while (clash);
        doInsert(100 + b * 8 + e, t, 1'b1);
      end
      while (model.size() > 0) doPop("R2 batch order", 1'b0);
    end

    // R7: slot list limit
    for (int i = 0; i < 4; i++) doInsert(30 + i, int'(nowTime) + 3, 1'b1);
    check("R7 no overflow at slot limit", int'(overflow), 0);
    doInsert(34, int'(nowTime) + 3, 1'b0);
    check("R7 overflow on full slot", int'(overflow), 1);
    for (int i = 0; i < 4; i++) doPop("R7 slot survivors", 1'b0);
    check("R7 overflow sticky", int'(overflow), 1);

    // R7: far store limit
    doReset();
    for (int i = 0; i < FD; i++) doInsert(40 + i, 20 + i * 3, 1'b1);
    check("R7 no overflow at far limit", int'(overflow), 0);
    doInsert(48, 60, 1'b0);
    check("R7 overflow on full far store", int'(overflow), 1);
    while (model.size() > 0) doPop("R4 far survivors", 1'b0);
    check("R7 overflow sticky after drain", int'(overflow), 1);

    monOn = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule